// File: doc/BRIEF.md
# Utility-Gated Page Promotion Selector

This block sits beside the memory controllers of a two-tier memory system, one fast and small and one slow and large. It watches the stream of serviced accesses and decides which pages are worth moving from the slow tier into the fast tier. For every page served by the slow tier it estimates how much stall time a move would save. Each access adds the tier latency gap, divided by one plus the number of other requests the same application had in flight at the time. Accesses that overlap with other requests therefore count for less than isolated ones. The running estimate is scaled by a per-application weight that software programs. The result is compared with a promotion threshold.

When the scaled value for a page goes strictly above the threshold, the block raises a single promotion request on a valid/acknowledge handshake. The request names the page and the application. The data copy itself is done elsewhere. Time is divided into epochs whose length is set by an input. At each epoch boundary all per-page estimates are cleared. The threshold also moves one step up or down, depending on whether the promotions issued in that epoch went over a programmable budget. The per-page estimate saturates at its 16-bit ceiling instead of wrapping.

Top module: `page_promo_sel`

## Requirements
- R1: After reset, `mig_valid` is 0 and `thr_level` equals the parameter THR_INIT (default 4000).
- R2: Each slow-tier access (`acc_valid`=1, `acc_slow`=1) adds LAT_DELTA/(1+`acc_outst`) to the page's estimate, truncated to an integer (default LAT_DELTA 1200). Utility is (estimate × weight) >> 4, saturated to 16 bits. A weight of 16 stands for 1.0.
- R3: A request is raised, with `mig_page` and `mig_app` taken from the access, at the clock edge that takes a slow-tier access whose updated utility is strictly greater than `thr_level`. `mig_valid` is visible from the edge that takes the access onwards.
- R4: In-flight requests reduce the contribution of each access. With weight 1.0 and threshold 4000, a page needs 4 isolated accesses (`acc_outst`=0) but 14 accesses with `acc_outst`=3.
- R5: A write with `sens_we`=1 sets the weight of application `sens_app` from the next cycle on. A weight of 0 means that application's pages are never promoted.
- R6: Accesses served by the fast tier (`acc_slow`=0) add nothing and never raise a request.
- R7: At most one request is outstanding. `mig_page` and `mig_app` hold until `mig_ack`, and `mig_valid` falls at the edge that takes the acknowledge. Estimates keep accumulating while a request waits. A page that qualifies during that time is not issued, but the page named in an issued request has its estimate cleared.
- R8: An epoch ends at the edge where the number of cycles since the previous end reaches `cfg_epoch_len`. A value of 1 ends an epoch at every edge. At the end of an epoch all page estimates are cleared.
- R9: At the end of an epoch the threshold rises by THR_STEP if more than `cfg_budget` promotions were issued in that epoch, and otherwise falls by THR_STEP. It is clamped to [THR_MIN, THR_MAX]. Defaults: step 1000, range 1000 to 8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_page | input | $clog2(NUM_PAGES) | Tracked page touched by the access |
| acc_app | input | $clog2(NUM_APPS) | Application that issued the access |
| acc_slow | input | 1 | 1 when the slow tier served the access, 0 when the fast tier did |
| acc_outst | input | OUTS_W | Other requests of the same application in flight at the time |
| sens_we | input | 1 | Write strobe for an application weight |
| sens_app | input | $clog2(NUM_APPS) | Application whose weight is written |
| sens_val | input | 8 | New weight, 4 fractional bits |
| cfg_epoch_len | input | EPOCH_W | Epoch length in cycles |
| cfg_budget | input | 16 | Promotions per epoch above which the threshold rises |
| mig_valid | output | 1 | A promotion request is pending |
| mig_page | output | $clog2(NUM_PAGES) | Page to promote |
| mig_app | output | $clog2(NUM_APPS) | Application owning that page |
| mig_ack | input | 1 | The consumer accepts the pending request |
| thr_level | output | 16 | Current promotion threshold |

## Verification
A corrupted page estimate shows up at the ports as a promotion that comes one or more accesses too early or too late. The bench counts accesses to the exact edge where `mig_valid` must rise, so an error of a single access is caught. If the epoch counter or threshold logic goes wrong, `thr_level` moves at the wrong edge or by the wrong amount. An estimate that survives an epoch boundary produces a request in the middle of an access burst that must stay silent. A broken pending-request hold changes `mig_page` before the acknowledge, and the scoreboard sees this at the handshake.

// File: rtl/promo_pkg.sv
// Shared widths and helpers for the page promotion selector.
// Assumes weights are unsigned fixed point with SENS_FRAC fraction bits.
package promo_pkg;
    localparam int UTIL_W    = 16;
    localparam int SENS_W    = 8;
    localparam int SENS_FRAC = 4;
    localparam int PROD_W    = UTIL_W + SENS_W;

    typedef logic [UTIL_W-1:0] util_t;
    typedef logic [SENS_W-1:0] sens_t;

    // Clamp a wide product to the utility range.
    function automatic util_t sat_util(input logic [PROD_W-1:0] v);
        return (|v[PROD_W-1:UTIL_W]) ? '1 : v[UTIL_W-1:0];
    endfunction
endpackage

// File: rtl/mlp_discount.sv
// Stall-saving estimate for one slow-tier access: the tier latency gap
// shared among the requests that overlapped with it.
// Assumes LAT_DELTA fits in UTIL_W bits.
module mlp_discount
    import promo_pkg::*;
#(
    parameter int OUTS_W    = 4,
    parameter int LAT_DELTA = 1200
) (
    input  logic [OUTS_W-1:0] outst,
    output util_t             delta
);
    util_t divisor;

    // Divide the latency gap by one plus the overlapping requests.
    always_comb begin
        divisor = util_t'(outst) + util_t'(1);
        delta   = util_t'(LAT_DELTA) / divisor;
    end
endmodule

// File: rtl/page_accum_table.sv
// Per-page saturating stall-saving accumulators with one update port,
// a single-page clear (for issued pages) and a clear-all (epoch end).
// Assumes clear requests win over an update of the same page.
module page_accum_table
    import promo_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [PAGE_W-1:0] upd_page,
    input  util_t             delta,
    input  logic              clr_one,
    input  logic              clr_all,
    output util_t             acc_upd
);
    util_t             acc_q [NUM_PAGES];
    logic [UTIL_W:0]   sum;

    // Saturating sum of the addressed page and the new contribution.
    always_comb begin
        sum     = {1'b0, acc_q[upd_page]} + {1'b0, delta};
        acc_upd = sum[UTIL_W] ? '1 : sum[UTIL_W-1:0];
    end

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        // Hold, clear or update the estimate of page g.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                acc_q[g] <= '0;
            end else if (upd_en && upd_page == PAGE_W'(g)) begin
                acc_q[g] <= clr_one ? '0 : acc_upd;
            end
        end
    end
endmodule

// File: rtl/sens_bank.sv
// Software-written per-application weights with one read port.
// Assumes a write takes effect from the cycle after the strobe.
module sens_bank
    import promo_pkg::*;
#(
    parameter int    NUM_APPS  = 4,
    parameter sens_t SENS_INIT = sens_t'(16),
    localparam int   APP_W     = $clog2(NUM_APPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [APP_W-1:0] wr_app,
    input  sens_t            wr_val,
    input  logic [APP_W-1:0] rd_app,
    output sens_t            rd_val
);
    sens_t w_q [NUM_APPS];

    for (genvar g = 0; g < NUM_APPS; g++) begin : g_app
        // Load the weight of application g on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q[g] <= SENS_INIT;
            end else if (we && wr_app == APP_W'(g)) begin
                w_q[g] <= wr_val;
            end
        end
    end

    assign rd_val = w_q[rd_app];
endmodule

// File: rtl/epoch_tuner.sv
// Epoch timer and adaptive threshold. Counts promotions per epoch and
// steps the threshold up or down at each epoch end, clamped to a range.
// Assumes THR_MIN <= THR_INIT <= THR_MAX and all fit in UTIL_W bits.
module epoch_tuner
    import promo_pkg::*;
#(
    parameter int EPOCH_W  = 16,
    parameter int CNT_W    = 16,
    parameter int THR_INIT = 4000,
    parameter int THR_MIN  = 1000,
    parameter int THR_MAX  = 8000,
    parameter int THR_STEP = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EPOCH_W-1:0] cfg_len,
    input  logic [CNT_W-1:0]   cfg_budget,
    input  logic               issued,
    output logic               epoch_end,
    output util_t              thr
);
    localparam logic [UTIL_W:0] MAX_X  = (UTIL_W+1)'(THR_MAX);
    localparam logic [UTIL_W:0] FLOOR  = (UTIL_W+1)'(THR_MIN + THR_STEP);
    localparam util_t           STEP_U = util_t'(THR_STEP);

    logic [EPOCH_W-1:0] cyc_q;
    logic [EPOCH_W:0]   cyc_inc;
    logic [CNT_W-1:0]   mig_cnt_q;
    logic [UTIL_W:0]    up_x;
    util_t              thr_up, thr_dn;

    // Epoch end detection and clamped threshold candidates.
    always_comb begin
        cyc_inc   = {1'b0, cyc_q} + 1'b1;
        epoch_end = cyc_inc >= {1'b0, cfg_len};
        up_x      = {1'b0, thr} + (UTIL_W+1)'(THR_STEP);
        thr_up    = (up_x > MAX_X) ? util_t'(THR_MAX) : up_x[UTIL_W-1:0];
        thr_dn    = ({1'b0, thr} < FLOOR) ? util_t'(THR_MIN) : thr - STEP_U;
    end

    // Cycle counter within the current epoch.
    always_ff @(posedge clk) begin
        if (!rst_n || epoch_end) cyc_q <= '0;
        else                     cyc_q <= cyc_inc[EPOCH_W-1:0];
    end

    // Saturating count of promotions issued in the current epoch.
    always_ff @(posedge clk) begin
        if (!rst_n || epoch_end)  mig_cnt_q <= '0;
        else if (issued && !(&mig_cnt_q)) mig_cnt_q <= mig_cnt_q + 1'b1;
    end

    // Threshold step at each epoch end.
    always_ff @(posedge clk) begin
        if (!rst_n)         thr <= util_t'(THR_INIT);
        else if (epoch_end) thr <= (mig_cnt_q > cfg_budget) ? thr_up : thr_dn;
    end
endmodule

// File: rtl/page_promo_sel.sv
// Top of the promotion selector. Turns slow-tier access events into
// weighted stall-saving estimates, compares them against the adaptive
// threshold and raises one promotion request at a time.
// Assumes the consumer holds mig_ack for one cycle per request; an access
// arriving in an epoch-end cycle is dropped.
module page_promo_sel
    import promo_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int NUM_APPS  = 4,
    parameter int OUTS_W    = 4,
    parameter int EPOCH_W   = 16,
    parameter int LAT_DELTA = 1200,
    parameter int THR_INIT  = 4000,
    parameter int THR_MIN   = 1000,
    parameter int THR_MAX   = 8000,
    parameter int THR_STEP  = 1000,
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int APP_W    = $clog2(NUM_APPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [PAGE_W-1:0]  acc_page,
    input  logic [APP_W-1:0]   acc_app,
    input  logic               acc_slow,
    input  logic [OUTS_W-1:0]  acc_outst,
    input  logic               sens_we,
    input  logic [APP_W-1:0]   sens_app,
    input  logic [7:0]         sens_val,
    input  logic [EPOCH_W-1:0] cfg_epoch_len,
    input  logic [15:0]        cfg_budget,
    output logic               mig_valid,
    output logic [PAGE_W-1:0]  mig_page,
    output logic [APP_W-1:0]   mig_app,
    input  logic               mig_ack,
    output logic [15:0]        thr_level
);
    util_t            delta, acc_upd, util, thr;
    sens_t            weight;
    logic             epoch_end, upd_en, issue;
    logic [PROD_W-1:0] prod;

    mlp_discount #(.OUTS_W(OUTS_W), .LAT_DELTA(LAT_DELTA)) u_disc (
        .outst (acc_outst),
        .delta (delta)
    );

    page_accum_table #(.NUM_PAGES(NUM_PAGES)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_page (acc_page),
        .delta    (delta),
        .clr_one  (issue),
        .clr_all  (epoch_end),
        .acc_upd  (acc_upd)
    );

    sens_bank #(.NUM_APPS(NUM_APPS)) u_sens (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sens_we),
        .wr_app (sens_app),
        .wr_val (sens_val),
        .rd_app (acc_app),
        .rd_val (weight)
    );

    epoch_tuner #(
        .EPOCH_W (EPOCH_W), .CNT_W(16),
        .THR_INIT(THR_INIT), .THR_MIN(THR_MIN),
        .THR_MAX (THR_MAX),  .THR_STEP(THR_STEP)
    ) u_tune (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_len    (cfg_epoch_len),
        .cfg_budget (cfg_budget),
        .issued     (issue),
        .epoch_end  (epoch_end),
        .thr        (thr)
    );

    // Weighted utility of the updated estimate and the issue decision.
    always_comb begin
        upd_en = acc_valid && acc_slow && !epoch_end;
        prod   = PROD_W'(acc_upd) * PROD_W'(weight);
        util   = sat_util(prod >> SENS_FRAC);
        issue  = upd_en && (util > thr) && !mig_valid;
    end

    // Single outstanding promotion request, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mig_valid <= 1'b0;
            mig_page  <= '0;
            mig_app   <= '0;
        end else if (mig_valid && mig_ack) begin
            mig_valid <= 1'b0;
        end else if (issue) begin
            mig_valid <= 1'b1;
            mig_page  <= acc_page;
            mig_app   <= acc_app;
        end
    end

    assign thr_level = thr;
endmodule

// File: rtl/page_promo_sel_checker.sv
// Temporal properties of the promotion selector, bound to the top.
module page_promo_sel_checker #(
    parameter int PAGE_W   = 4,
    parameter int APP_W    = 2,
    parameter int THR_MIN  = 1000,
    parameter int THR_MAX  = 8000,
    parameter int THR_STEP = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_slow,
    input logic              mig_valid,
    input logic              mig_ack,
    input logic [PAGE_W-1:0] mig_page,
    input logic [APP_W-1:0]  mig_app,
    input logic [15:0]       thr_level
);
    // R7: a waiting request keeps its contents until acknowledged.
    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid && !mig_ack |=> mig_valid && $stable(mig_page) && $stable(mig_app));

    // R7: the acknowledge retires the request.
    p_ack_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid && mig_ack |=> !mig_valid);

    // R6: without a slow-tier access no new request appears.
    p_fast_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mig_valid && !(acc_valid && acc_slow) |=> !mig_valid);

    // R9: threshold stays inside its range.
    p_thr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_level >= 16'(THR_MIN) && thr_level <= 16'(THR_MAX));

    // R9: threshold moves by one step or lands on a bound.
    p_thr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_level) |->
            (thr_level == $past(thr_level) + 16'(THR_STEP)) ||
            (thr_level == $past(thr_level) - 16'(THR_STEP)) ||
            (thr_level == 16'(THR_MIN)) || (thr_level == 16'(THR_MAX)));
endmodule

bind page_promo_sel page_promo_sel_checker #(
    .PAGE_W(PAGE_W), .APP_W(APP_W),
    .THR_MIN(THR_MIN), .THR_MAX(THR_MAX), .THR_STEP(THR_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_slow  (acc_slow),
    .mig_valid (mig_valid),
    .mig_ack   (mig_ack),
    .mig_page  (mig_page),
    .mig_app   (mig_app),
    .thr_level (thr_level)
);

// File: tb/page_promo_sel_test.sv
// Scoreboard bench: the driver pushes expected promotions, a monitor pops
// and compares them at each accepted handshake.
module page_promo_sel_test;
    localparam int BIG_LEN = 60000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_slow, sens_we, mig_ack;
    logic [3:0]  acc_page, acc_outst;
    logic [1:0]  acc_app, sens_app;
    logic [7:0]  sens_val;
    logic [15:0] cfg_epoch_len, cfg_budget;
    logic        mig_valid;
    logic [3:0]  mig_page;
    logic [1:0]  mig_app;
    logic [15:0] thr_level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_q[$];

    page_promo_sel uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_page(acc_page), .acc_app(acc_app),
        .acc_slow(acc_slow), .acc_outst(acc_outst),
        .sens_we(sens_we), .sens_app(sens_app), .sens_val(sens_val),
        .cfg_epoch_len(cfg_epoch_len), .cfg_budget(cfg_budget),
        .mig_valid(mig_valid), .mig_page(mig_page), .mig_app(mig_app),
        .mig_ack(mig_ack), .thr_level(thr_level)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare each accepted request with the scoreboard head.
    always @(negedge clk) begin
        #5;
        if (rst_n && mig_valid && mig_ack) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected request", {mig_page, mig_app}, -1);
            end else begin
                chk("R3 request page/app", {mig_page, mig_app}, exp_q.pop_front());
            end
        end
    end

    task automatic burst(input int page, input int app, input bit slow,
                         input int outst, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b1; acc_page = 4'(page); acc_app = 2'(app);
            acc_slow = slow;  acc_outst = 4'(outst);
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_req(input int page, input int app);
        exp_q.push_back({page[3:0], app[1:0]});
    endtask

    task automatic ack();
        @(negedge clk); mig_ack = 1'b1;
        @(negedge clk); mig_ack = 1'b0;
    endtask

    task automatic set_sens(input int app, input int val);
        @(negedge clk); sens_we = 1'b1; sens_app = 2'(app); sens_val = 8'(val);
        @(negedge clk); sens_we = 1'b0;
    endtask

    task automatic end_epochs(input int n);
        @(negedge clk); cfg_epoch_len = 16'd1;
        repeat (n) @(negedge clk);
        cfg_epoch_len = 16'(BIG_LEN);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            chk("watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_slow = 1'b0; acc_page = '0;
        acc_app = '0; acc_outst = '0; sens_we = 1'b0; sens_app = '0;
        sens_val = '0; mig_ack = 1'b0;
        cfg_epoch_len = 16'(BIG_LEN); cfg_budget = 16'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 mig_valid", mig_valid, 0);
        chk("R1 threshold", thr_level, 4000);

        // R2/R3: isolated accesses, 1200 each, request on the 4th (4800 > 4000)
        burst(3, 0, 1, 0, 3);
        chk("R2 no request at 3600", mig_valid, 0);
        burst(3, 0, 1, 0, 1);
        chk("R3 request at 4800", mig_valid, 1);
        chk("R3 page", mig_page, 3);
        expect_req(3, 0); ack();
        chk("R7 valid drops after ack", mig_valid, 0);

        // R4: outst=3 gives 300 each; 13 -> 3900 none, 14 -> 4200 request
        burst(5, 0, 1, 3, 13);
        chk("R4 no request at 3900", mig_valid, 0);
        burst(5, 0, 1, 3, 1);
        chk("R4 request at 4200", mig_valid, 1);
        expect_req(5, 0); ack();

        // R5: weight 4.0 for app 1, single access gives 4800
        set_sens(1, 64);
        burst(7, 1, 1, 0, 1);
        chk("R5 weighted request", mig_valid, 1);
        expect_req(7, 1);
        // R7: page 8 qualifies while page 7 waits
        burst(8, 1, 1, 0, 1);
        chk("R7 still pending", mig_valid, 1);
        chk("R7 page held", mig_page, 7);
        ack();
        chk("R7 retired", mig_valid, 0);
        burst(8, 1, 1, 0, 1);
        chk("R7 kept estimate reissues", mig_valid, 1);
        chk("R7 page 8", mig_page, 8);
        expect_req(8, 1); ack();

        // R5: weight 0 never promotes
        set_sens(2, 0);
        burst(11, 2, 1, 0, 6);
        chk("R5 zero weight silent", mig_valid, 0);

        // R6: fast-tier accesses add nothing
        burst(9, 1, 0, 0, 5);
        chk("R6 fast tier silent", mig_valid, 0);

        // R9: 4 promotions > budget 1 -> up; then 0 -> down; then clamp at min
        end_epochs(1);
        chk("R9 step up", thr_level, 5000);
        end_epochs(1);
        chk("R9 step down", thr_level, 4000);
        end_epochs(5);
        chk("R9 clamp at min", thr_level, 1000);

        // R8: outst=15 gives 75 each; estimate cleared at epoch end
        burst(12, 0, 1, 15, 10);
        end_epochs(1);
        burst(12, 0, 1, 15, 10);
        chk("R8 cleared estimate (750)", mig_valid, 0);
        burst(12, 0, 1, 15, 3);
        chk("R8 975 not above", mig_valid, 0);
        burst(12, 0, 1, 15, 1);
        chk("R8 1050 above", mig_valid, 1);
        expect_req(12, 0); ack();

        // R9: budget 0, one promotion -> up to 2000
        cfg_budget = 16'd0;
        end_epochs(1);
        chk("R9 rise over budget 0", thr_level, 2000);

        // R3: threshold 2000 gates: 2400 needed
        burst(3, 0, 1, 0, 1);
        chk("R3 1200 below 2000", mig_valid, 0);
        burst(3, 0, 1, 0, 1);
        chk("R3 2400 above 2000", mig_valid, 1);
        expect_req(3, 0); ack();

        // R8: programmable length of 40 cycles
        @(negedge clk); cfg_epoch_len = 16'd1;
        @(negedge clk); cfg_epoch_len = 16'd40;
        chk("R9 rise to 3000", thr_level, 3000);
        repeat (39) @(negedge clk);
        chk("R8 before 40th edge", thr_level, 3000);
        @(negedge clk);
        chk("R8 at 40th edge", thr_level, 2000);
        cfg_epoch_len = 16'(BIG_LEN);

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule